// File: doc/BRIEF.md
# I/Q Table-Feedback Delta-Sigma Modulator

This block is a first-order digital delta-sigma modulator with two loops, one for the in-phase channel and one for the quadrature channel. Each loop turns an oversampled 12-bit signed sample into a 4-bit code for a coarse DAC. The value fed back into each loop's integrator is not the ideal quantizer level. It is taken from a trainable two-dimensional table that is addressed by the current pair of codes. The loop therefore forces the locally averaged table output to follow the input, so the code stream approximates the inverse of the transfer curve stored in the table. That curve is a measured amplifier-plus-DAC characteristic, and the block interpolates between table points through oversampling.

Normal operation has three steps. With `run_en` low, software or a training engine fills all 256 table entries through the write port. Then `run_en` is raised and samples are streamed in at the oversampled rate (typically 128 times the symbol band). Setting `bypass` replaces every table read with the ideal uniform quantizer level, which gives an output without predistortion for comparison.

Top module: `iq_lutfb_dsm`

## Requirements
- R1: While `rst_n` is low and in the first cycle after its release, both integrators read zero, both codes read 8 (mid-scale) and `out_valid` is low.
- R2: A sample is accepted on a rising edge where `run_en` and `in_valid` are both high. For each channel the new integrator value is acc + x − fb. The new code is floor(acc/256) + 8, clamped to 0..15. Both appear on the outputs right after that edge, and `out_valid` is high for exactly that one cycle.
- R3: With `bypass` low, fb is read from the table entry at address {I code, Q code}, with the I code in address bits 7:4 and the Q code in bits 3:0. The codes used are those present before the edge. The I loop uses the entry's I value and the Q loop uses its Q value.
- R4: With `bypass` high, each channel's fb is (code − 8)·256 + 128, the centre of its own quantizer cell, and the table is not read.
- R5: Each 16-bit integrator saturates at +32767 and −32768 and never wraps around.
- R6: The codes clamp at 15 for integrator values of 1792 and above, and at 0 for values below −1792.
- R7: On an edge where no sample is accepted, the integrators and codes keep their values and `out_valid` is low.
- R8: A table write (`tbl_we` high) updates entry `tbl_addr` only while `run_en` is low. While `run_en` is high the write has no effect.
- R9: An entry written on an edge is used by a sample accepted on the very next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | High: modulate samples; low: table may be written |
| bypass | input | 1 | Use ideal quantizer levels as feedback |
| in_valid | input | 1 | Sample strobe |
| in_i | input | 12 | I sample, signed two's complement |
| in_q | input | 12 | Q sample, signed two's complement |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 8 | Table entry address {I code, Q code} |
| tbl_wr_i | input | 12 | I feedback value to store, signed |
| tbl_wr_q | input | 12 | Q feedback value to store, signed |
| out_valid | output | 1 | High the cycle after an accepted sample |
| code_i | output | 4 | I quantizer code |
| code_q | output | 4 | Q quantizer code |

## Verification
Every result of an accepted sample shows up one register stage later: the codes, the `out_valid` strobe and the integrator state all change on the same edge that accepted the sample. A table write is visible to the read path from the next edge on. The bench applies each stimulus at a falling edge and advances its behavioural model at the same moment. It compares `code_i`, `code_q` and `out_valid` against the model at the following falling edge, half a period after the design's registers have taken the new values. Ignored writes (R8) and idle cycles (R7) are detected through their effect on later codes, because the model never applies them.

// File: rtl/iq_dsm_pkg.sv
package iq_dsm_pkg;
    localparam int NCH = 2;

    typedef enum logic {
        CH_I = 1'b0,
        CH_Q = 1'b1
    } chan_e;
endpackage

// File: rtl/dsm_fb_table.sv
module dsm_fb_table #(
    parameter int DW = 12,
    parameter int CW = 4
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [2*CW-1:0]      waddr,
    input  logic signed [DW-1:0] wdat_i,
    input  logic signed [DW-1:0] wdat_q,
    input  logic [2*CW-1:0]      raddr,
    output logic signed [DW-1:0] rdat_i,
    output logic signed [DW-1:0] rdat_q
);
    localparam int AW    = 2 * CW;
    localparam int DEPTH = 1 << AW;

    logic [2*DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= {wdat_i, wdat_q};
        end
    end

    always_comb begin
        rdat_i = mem_q[raddr][2*DW-1:DW];
        rdat_q = mem_q[raddr][DW-1:0];
    end
endmodule

// File: rtl/dsm_fb_sel.sv
module dsm_fb_sel #(
    parameter int DW = 12,
    parameter int CW = 4
) (
    input  logic                 bypass,
    input  logic [CW-1:0]        code,
    input  logic signed [DW-1:0] tbl_val,
    output logic signed [DW-1:0] fb
);
    localparam int PAD = DW - CW - 1;

    logic signed [DW-1:0] level;

    always_comb begin
        // (code - mid) * step + step/2, built from the offset-binary code
        level = {~code[CW-1], code[CW-2:0], 1'b1, {PAD{1'b0}}};
        fb    = bypass ? level : tbl_val;
    end
endmodule

// File: rtl/dsm_chan.sv
module dsm_chan #(
    parameter int DW = 12,
    parameter int CW = 4,
    parameter int IW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic signed [DW-1:0] x,
    input  logic signed [DW-1:0] fb,
    output logic [CW-1:0]        code,
    output logic signed [IW-1:0] acc
);
    localparam int SW     = IW + 2;
    localparam int SH     = DW - CW;
    localparam int LEVELS = 1 << CW;
    localparam int HALF   = LEVELS / 2;
    localparam int CRW    = IW - SH;

    localparam logic signed [SW-1:0] SMAX = {3'b000, {(IW-1){1'b1}}};
    localparam logic signed [SW-1:0] SMIN = {3'b111, {(IW-1){1'b0}}};

    typedef struct packed {
        logic [IW-1:0] acc;
        logic [CW-1:0] code;
    } chan_st_t;

    chan_st_t              st_d, st_q;
    logic signed [SW-1:0]  sum;
    logic signed [IW-1:0]  sat;
    logic signed [CRW-1:0] coarse;
    logic signed [CRW:0]   idx;
    logic [CW-1:0]         qcode;

    always_comb begin
        st_d = st_q;
        sum  = {{2{st_q.acc[IW-1]}}, st_q.acc}
             + {{(SW-DW){x[DW-1]}}, x}
             - {{(SW-DW){fb[DW-1]}}, fb};
        if (sum > SMAX) begin
            sat = SMAX[IW-1:0];
        end else if (sum < SMIN) begin
            sat = SMIN[IW-1:0];
        end else begin
            sat = sum[IW-1:0];
        end
        coarse = sat[IW-1:SH];
        idx    = {coarse[CRW-1], coarse} + (CRW+1)'(HALF);
        if (idx < 0) begin
            qcode = '0;
        end else if (idx > (CRW+1)'(LEVELS-1)) begin
            qcode = CW'(LEVELS-1);
        end else begin
            qcode = idx[CW-1:0];
        end
        if (en) begin
            st_d.acc  = sat;
            st_d.code = qcode;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.acc  <= '0;
            st_q.code <= CW'(HALF);
        end else begin
            st_q <= st_d;
        end
    end

    assign code = st_q.code;
    assign acc  = st_q.acc;
endmodule

// File: rtl/iq_lutfb_dsm.sv
module iq_lutfb_dsm
    import iq_dsm_pkg::*;
#(
    parameter int DW = 12,
    parameter int CW = 4,
    parameter int IW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic          bypass,
    input  logic          in_valid,
    input  logic [DW-1:0] in_i,
    input  logic [DW-1:0] in_q,
    input  logic          tbl_we,
    input  logic [2*CW-1:0] tbl_addr,
    input  logic [DW-1:0] tbl_wr_i,
    input  logic [DW-1:0] tbl_wr_q,
    output logic          out_valid,
    output logic [CW-1:0] code_i,
    output logic [CW-1:0] code_q
);
    typedef struct packed {
        logic ov;
    } top_st_t;

    top_st_t st_d, st_q;

    logic                 accept;
    logic                 wr_ok;
    logic signed [DW-1:0] x_w   [NCH];
    logic signed [DW-1:0] tbl_w [NCH];
    logic signed [DW-1:0] fb_w  [NCH];
    logic [CW-1:0]        code_w [NCH];
    logic signed [IW-1:0] acc_w [NCH];

    assign accept    = run_en & in_valid;
    assign wr_ok     = tbl_we & ~run_en;
    assign x_w[CH_I] = in_i;
    assign x_w[CH_Q] = in_q;

    dsm_fb_table #(.DW(DW), .CW(CW)) u_table (
        .clk    (clk),
        .we     (wr_ok),
        .waddr  (tbl_addr),
        .wdat_i (tbl_wr_i),
        .wdat_q (tbl_wr_q),
        .raddr  ({code_w[CH_I], code_w[CH_Q]}),
        .rdat_i (tbl_w[CH_I]),
        .rdat_q (tbl_w[CH_Q])
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dsm_fb_sel #(.DW(DW), .CW(CW)) u_sel (
            .bypass  (bypass),
            .code    (code_w[c]),
            .tbl_val (tbl_w[c]),
            .fb      (fb_w[c])
        );

        dsm_chan #(.DW(DW), .CW(CW), .IW(IW)) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (accept),
            .x     (x_w[c]),
            .fb    (fb_w[c]),
            .code  (code_w[c]),
            .acc   (acc_w[c])
        );
    end

    always_comb begin
        st_d    = st_q;
        st_d.ov = accept;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.ov;
    assign code_i    = code_w[CH_I];
    assign code_q    = code_w[CH_Q];
endmodule

// File: rtl/iq_lutfb_dsm_chk.sv
module iq_lutfb_dsm_chk #(
    parameter int DW = 12,
    parameter int CW = 4,
    parameter int IW = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 run_en,
    input logic                 in_valid,
    input logic                 out_valid,
    input logic [CW-1:0]        code_i,
    input logic [CW-1:0]        code_q,
    input logic signed [IW-1:0] acc_i,
    input logic signed [IW-1:0] acc_q
);
    localparam int SH     = DW - CW;
    localparam int LEVELS = 1 << CW;
    localparam int HALF   = LEVELS / 2;
    localparam logic signed [IW-1:0] TOP_EDGE = IW'((HALF - 1) << SH);
    localparam logic signed [IW-1:0] NEAR_MAX = IW'(1 << (IW - 2));

    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_state: assert (code_i == CW'(HALF) && code_q == CW'(HALF)
                                      && !out_valid && acc_i == '0 && acc_q == '0);
        end
    end

    a_r2_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && in_valid) |=> out_valid);

    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(run_en && in_valid) |=> (!out_valid && $stable(code_i) && $stable(code_q)
                                   && $stable(acc_i) && $stable(acc_q)));

    a_r5_no_wrap_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i > NEAR_MAX) |=> (acc_i > 0));

    a_r5_no_wrap_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q < -NEAR_MAX) |=> (acc_q < 0));

    a_r6_clamp_top: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i >= TOP_EDGE) |-> (code_i == CW'(LEVELS - 1)));

    a_r6_clamp_bottom: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q < -TOP_EDGE) |-> (code_q == '0));
endmodule

bind iq_lutfb_dsm iq_lutfb_dsm_chk #(.DW(DW), .CW(CW), .IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .code_i    (code_i),
    .code_q    (code_q),
    .acc_i     (acc_w[0]),
    .acc_q     (acc_w[1])
);

// File: tb/iq_lutfb_dsm_tb.sv
`timescale 1ns/1ps
module iq_lutfb_dsm_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        run_en = 1'b0;
    logic        bypass = 1'b0;
    logic        in_valid = 1'b0;
    logic [11:0] in_i = '0;
    logic [11:0] in_q = '0;
    logic        tbl_we = 1'b0;
    logic [7:0]  tbl_addr = '0;
    logic [11:0] tbl_wr_i = '0;
    logic [11:0] tbl_wr_q = '0;
    logic        out_valid;
    logic [3:0]  code_i;
    logic [3:0]  code_q;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;
    string ptag = "R1";

    int m_acc [2];
    int m_code [2];
    int m_ov;
    int mt [2][256];

    always #5 clk = ~clk;

    iq_lutfb_dsm u_dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .bypass(bypass),
        .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wr_i(tbl_wr_i), .tbl_wr_q(tbl_wr_q),
        .out_valid(out_valid), .code_i(code_i), .code_q(code_q)
    );

    task automatic check_now();
        vectors++;
        if (int'(code_i) != m_code[0] || int'(code_q) != m_code[1] || int'(out_valid) != m_ov) begin
            fails++;
            $display("FAIL %s: got code_i=%0d code_q=%0d out_valid=%0d, expected %0d %0d %0d",
                     ptag, code_i, code_q, out_valid, m_code[0], m_code[1], m_ov);
        end
    endtask

    function automatic int quant(input int a);
        int q = (a >>> 8) + 8;
        if (q < 0) q = 0;
        if (q > 15) q = 15;
        return q;
    endfunction

    task automatic model_step(input bit run, input bit byp, input bit vld,
                              input int xi, input int xq,
                              input bit we, input int addr, input int wi, input int wq);
        int xs [2];
        xs[0] = xi;
        xs[1] = xq;
        if (run && vld) begin
            int fb [2];
            int ad = m_code[0] * 16 + m_code[1];
            for (int c = 0; c < 2; c++) begin
                fb[c] = byp ? (m_code[c] - 8) * 256 + 128 : mt[c][ad];
            end
            for (int c = 0; c < 2; c++) begin
                int a = m_acc[c] + xs[c] - fb[c];
                if (a > 32767) a = 32767;
                if (a < -32768) a = -32768;
                m_acc[c] = a;
                m_code[c] = quant(a);
            end
            m_ov = 1;
        end else begin
            m_ov = 0;
        end
        if (we && !run) begin
            mt[0][addr] = wi;
            mt[1][addr] = wq;
        end
    endtask

    task automatic cyc(input string tg, input bit run, input bit byp, input bit vld,
                       input int xi, input int xq,
                       input bit we, input int addr, input int wi, input int wq);
        @(negedge clk);
        check_now();
        run_en   = run;
        bypass   = byp;
        in_valid = vld;
        in_i     = 12'(xi);
        in_q     = 12'(xq);
        tbl_we   = we;
        tbl_addr = 8'(addr);
        tbl_wr_i = 12'(wi);
        tbl_wr_q = 12'(wq);
        model_step(run, byp, vld, xi, xq, we, addr, wi, wq);
        ptag = tg;
    endtask

    function automatic int rnd12();
        return int'($urandom_range(0, 4095)) - 2048;
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL R2: watchdog expired, got no completion, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        m_acc[0] = 0; m_acc[1] = 0;
        m_code[0] = 8; m_code[1] = 8;
        m_ov = 0;
        #1 rst_n = 1'b0;
        // R1: reset state, also with run and valid driven during reset
        ptag = "R1";
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check_now();
            run_en = 1'b1;
            in_valid = 1'b1;
            in_i = 12'd1000;
        end
        @(negedge clk);
        check_now();
        run_en = 1'b0;
        in_valid = 1'b0;
        in_i = '0;
        rst_n = 1'b1;
        ptag = "R1";

        // training: fill the whole table while run_en is low (R8 write path)
        for (int a = 0; a < 256; a++) begin
            int ci = a / 16;
            int cq = a % 16;
            int li = (ci - 8) * 256 + 128;
            int lq = (cq - 8) * 256 + 128;
            cyc("R8", 0, 0, 0, 0, 0, 1, a, (li * 3) / 4 + (cq - 8) * 12, (lq * 3) / 4 + (ci - 8) * 9);
        end

        // R9: rewrite the entry at the current codes, use it on the next edge
        cyc("R9", 0, 0, 0, 0, 0, 1, m_code[0] * 16 + m_code[1], 700, -650);
        cyc("R9", 1, 0, 1, 0, 0, 0, 0, 0, 0);

        // R8: write attempted while running must be ignored
        cyc("R8", 1, 0, 0, 0, 0, 1, m_code[0] * 16 + m_code[1], 2000, -2000);
        cyc("R8", 1, 0, 1, 300, -300, 0, 0, 0, 0);
        cyc("R8", 1, 0, 1, 300, -300, 0, 0, 0, 0);

        // R3 R7: table feedback with random samples, gaps and idle spells
        for (int k = 0; k < 3000; k++) begin
            int r = int'($urandom_range(0, 99));
            bit run = (r >= 8);
            bit vld = (r >= 20);
            bit we = (r < 4);
            cyc((run && vld) ? "R3" : "R7", run, 0, vld, rnd12(), rnd12(),
                we, int'($urandom_range(0, 255)), rnd12(), rnd12());
        end

        // R4: bypass with a slow ramp and random samples
        for (int k = 0; k < 600; k++) begin
            int xi = ((k * 37) % 4096) - 2048;
            cyc("R4", 1, 1, (k % 5) != 0, xi, rnd12(), 0, 0, 0, 0);
        end

        // R5 R6: zero feedback drives integrators to their rails
        for (int a = 0; a < 256; a++) begin
            cyc("R5", 0, 0, 0, 0, 0, 1, a, 0, 0);
        end
        for (int k = 0; k < 24; k++) begin
            cyc("R5 R6", 1, 0, 1, 2047, -2048, 0, 0, 0, 0);
        end
        for (int k = 0; k < 40; k++) begin
            cyc("R5 R6", 1, 0, 1, -2048, 2047, 0, 0, 0, 0);
        end
        for (int k = 0; k < 40; k++) begin
            cyc("R5 R6", 1, 0, 1, 2047, -2048, 0, 0, 0, 0);
        end
        cyc("R2", 1, 0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        check_now();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule